// File: doc/BRIEF.md
# Early Termination Enable Controller

This block sits beside the node-unit array of an iterative, bit-serial message-passing decoder that works on two frames at once. The frames occupy two slots. While one slot's frame is processed by the check-node group, the other slot's frame is processed by the variable-node group. The two groups trade slots at the end of every phase of `PHASE_LEN` cycles, so one full iteration of a frame takes two phases.

The controller combines the per-check parity results of the ordinary variable-to-check messages with an OR tree. It samples that result only on the last cycle of a check phase. A zero result means every parity constraint holds, and the frame in that slot is marked converged. From then on, both node groups stay disabled whenever they hold that slot, for the rest of the frame's iteration budget. A one-cycle hard-decision strobe for the slot tells the variable nodes to produce their final decisions at the start of the next phase.

A frame that never converges runs all `MAX_ITER` iterations and then raises the same strobe. The phase timing runs freely and never depends on convergence, so frame start times, and with them the throughput, are the same whether a frame terminates early or not.

Top module: `et_enable_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `chk_en`, `var_en` and `hd_strobe` are 0 and `chk_slot` is 0.
- R2: `chk_slot` holds for `PHASE_LEN` cycles and then inverts. It starts at 0 after reset and never depends on parity or convergence.
- R3: `new_frame` is accepted only on the last cycle of a phase. It loads the slot that is not in the check group at that moment, which is the slot that enters the check group next. It clears that slot's iteration count and termination state and starts the slot running. A strobe on any other cycle has no effect.
- R4: `chk_en` is 1 exactly when the slot named by `chk_slot` is running. `var_en` is 1 exactly when the other slot is running.
- R5: On the last cycle of a check phase, a running slot becomes converged if the OR of all `parity` bits is 0. `parity` is ignored on every other cycle, and a single set bit in any position prevents convergence.
- R6: Once a slot has converged or used its budget, both enables stay 0 whenever that slot is in either group, until a new frame is loaded into it.
- R7: After convergence, `hd_strobe[s]` (bit index = slot number) is 1 for exactly the first cycle of the next phase.
- R8: A slot that does not converge ends its budget at the last cycle of its `MAX_ITER`-th variable phase. `hd_strobe[s]` is then 1 for the first cycle of the next phase, and the slot stops running.
- R9: When `new_frame` arrives on the same cycle that a slot ends its budget, the finishing frame still gets its strobe and the new frame starts running in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_frame | input | 1 | Load a new frame into the slot entering the check group |
| parity | input | N_CHK | Per-check parity failure flags, 1 = constraint violated |
| chk_en | output | 1 | Enable for the check-node group |
| var_en | output | 1 | Enable for the variable-node group |
| chk_slot | output | 1 | Slot currently held by the check-node group |
| hd_strobe | output | 2 | Per-slot final hard-decision strobe |

## Verification
The bench builds the block with five checks, a phase of two cycles and a budget of three iterations. The odd check count exercises the padded leaves of the OR tree. The short phase and small budget let one run reach every case: convergence in both slots, a parity-zero sample off the sampling cycle, an exhausted budget, a reload that lands on the cycle a budget ends, and a new-frame strobe that must be ignored. A separate pass lets a frame run its full budget against a single set parity bit and times its strobe to the exact cycle.

// File: rtl/et_pkg.sv
package et_pkg;

    localparam int NUM_SLOTS = 2;

    typedef logic slot_t;

    typedef struct packed {
        logic running;
        logic hd;
    } slot_stat_t;

    function automatic slot_t peer_slot(slot_t s);
        return ~s;
    endfunction

endpackage

// File: rtl/et_or_tree.sv
module et_or_tree #(
    parameter int N = 176
) (
    input  logic [N-1:0] vec,
    output logic         any_set
);
    localparam int LVL  = (N > 1) ? $clog2(N) : 0;
    localparam int SIZE = 1 << LVL;

    logic [2*SIZE-1:1] nd;

    for (genvar j = 0; j < SIZE; j++) begin : g_leaf
        if (j < N) begin : g_real
            assign nd[SIZE+j] = vec[j];
        end else begin : g_pad
            assign nd[SIZE+j] = 1'b0;
        end
    end

    for (genvar i = 1; i < SIZE; i++) begin : g_node
        assign nd[i] = nd[2*i] | nd[2*i+1];
    end

    assign any_set = nd[1];

endmodule

// File: rtl/et_phase_timer.sv
module et_phase_timer #(
    parameter int PHASE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    output logic phase_first,
    output logic phase_last,
    output logic chk_slot
);
    localparam int PH_W = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
    localparam logic [PH_W-1:0] PH_END = PH_W'(PHASE_LEN - 1);

    logic [PH_W-1:0] ph_cnt;

    assign phase_first = (ph_cnt == '0);
    assign phase_last  = (ph_cnt == PH_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_cnt   <= '0;
            chk_slot <= 1'b0;
        end else if (phase_last) begin
            ph_cnt   <= '0;
            chk_slot <= ~chk_slot;
        end else begin
            ph_cnt   <= ph_cnt + 1'b1;
        end
    end

    // R2: slot stays put inside a phase
    p_slot_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !phase_last |=> $stable(chk_slot));
    // R2: slot swaps after the last cycle of a phase
    p_slot_flip_r2: assert property (@(posedge clk) disable iff (rst)
        phase_last |=> (chk_slot != $past(chk_slot)));

endmodule

// File: rtl/et_slot_ctrl.sv
module et_slot_ctrl #(
    parameter int MAX_ITER = 15,
    parameter int IT_W     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic chk_last,
    input  logic var_last,
    input  logic par_fail,
    output logic running,
    output logic hd
);
    localparam logic [IT_W-1:0] IT_LAST = IT_W'(MAX_ITER - 1);

    logic [IT_W-1:0] iter;
    logic            fin_conv;
    logic            fin_budget;

    assign fin_conv   = chk_last & running & ~par_fail;
    assign fin_budget = var_last & running & (iter == IT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            iter    <= '0;
            hd      <= 1'b0;
        end else begin
            hd <= fin_conv | fin_budget;
            if (load) begin
                running <= 1'b1;
                iter    <= '0;
            end else if (fin_conv || fin_budget) begin
                running <= 1'b0;
            end else if (var_last && running) begin
                iter    <= iter + 1'b1;
            end
        end
    end

    // R7, R8: a strobe only follows a running frame
    p_hd_after_run_r8: assert property (@(posedge clk) disable iff (rst)
        hd |-> $past(running));
    // R8: iteration count never reaches the budget
    p_iter_cap_r8: assert property (@(posedge clk) disable iff (rst)
        iter < IT_W'(MAX_ITER));
    // R6: an idle slot wakes only through a load
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!running && !load) |=> !running);

endmodule

// File: rtl/et_enable_ctrl.sv
module et_enable_ctrl
    import et_pkg::*;
#(
    parameter int N_CHK     = 176,
    parameter int PHASE_LEN = 4,
    parameter int MAX_ITER  = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             new_frame,
    input  logic [N_CHK-1:0] parity,
    output logic             chk_en,
    output logic             var_en,
    output logic             chk_slot,
    output logic [1:0]       hd_strobe
);
    localparam int IT_W = $clog2(MAX_ITER + 1);

    logic       phase_first;
    logic       phase_last;
    logic       any_fail;
    slot_stat_t stat [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] run_vec;

    et_phase_timer #(.PHASE_LEN(PHASE_LEN)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .phase_first (phase_first),
        .phase_last  (phase_last),
        .chk_slot    (chk_slot)
    );

    et_or_tree #(.N(N_CHK)) u_or (
        .vec     (parity),
        .any_set (any_fail)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic in_chk;
        assign in_chk = (chk_slot == slot_t'(s));

        et_slot_ctrl #(.MAX_ITER(MAX_ITER), .IT_W(IT_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (new_frame & phase_last & ~in_chk),
            .chk_last (phase_last & in_chk),
            .var_last (phase_last & ~in_chk),
            .par_fail (any_fail),
            .running  (stat[s].running),
            .hd       (stat[s].hd)
        );

        assign run_vec[s]   = stat[s].running;
        assign hd_strobe[s] = stat[s].hd;
    end

    assign chk_en = run_vec[chk_slot];
    assign var_en = run_vec[peer_slot(chk_slot)];

    // R7: strobes land on the first cycle of a phase
    p_hd_align_r7: assert property (@(posedge clk) disable iff (rst)
        (|hd_strobe) |-> phase_first);
    // R6: convergence switches the variable group off for that frame
    p_conv_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_last && chk_en && !any_fail) |=> !var_en);

endmodule

// File: tb/tb_et_enable_ctrl.sv
module tb_et_enable_ctrl;

    localparam int NC = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          new_frame = 1'b0;
    logic [NC-1:0] parity = '0;
    logic          chk_en, var_en, chk_slot;
    logic [1:0]    hd_strobe;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    et_enable_ctrl #(.N_CHK(NC), .PHASE_LEN(2), .MAX_ITER(3)) dut (
        .clk       (clk),
        .rst       (rst),
        .new_frame (new_frame),
        .parity    (parity),
        .chk_en    (chk_en),
        .var_en    (var_en),
        .chk_slot  (chk_slot),
        .hd_strobe (hd_strobe)
    );

    // {req, nf, parity, chk_slot, chk_en, var_en, hd}
    localparam int NV = 21;
    localparam logic [14:0] VEC [NV] = '{
        {4'd1, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 2'b00}, // c0  R1 reset state
        {4'd3, 1'b1, 5'b00000, 1'b0, 1'b0, 1'b0, 2'b00}, // c1  R3 load slot 1
        {4'd4, 1'b0, 5'b00000, 1'b1, 1'b1, 1'b0, 2'b00}, // c2  R4
        {4'd5, 1'b1, 5'b00100, 1'b1, 1'b1, 1'b0, 2'b00}, // c3  R5 fail, R3 load slot 0
        {4'd4, 1'b0, 5'b00000, 1'b0, 1'b1, 1'b1, 2'b00}, // c4  R4 both busy
        {4'd5, 1'b0, 5'b10000, 1'b0, 1'b1, 1'b1, 2'b00}, // c5  R5 top bit blocks
        {4'd2, 1'b0, 5'b00000, 1'b1, 1'b1, 1'b1, 2'b00}, // c6  R2
        {4'd5, 1'b0, 5'b00000, 1'b1, 1'b1, 1'b1, 2'b00}, // c7  R5 slot 1 converges
        {4'd7, 1'b0, 5'b00000, 1'b0, 1'b1, 1'b0, 2'b10}, // c8  R7 strobe slot 1
        {4'd6, 1'b0, 5'b00001, 1'b0, 1'b1, 1'b0, 2'b00}, // c9  R6
        {4'd6, 1'b0, 5'b00000, 1'b1, 1'b0, 1'b1, 2'b00}, // c10 R6 slot 1 stays off
        {4'd6, 1'b0, 5'b00000, 1'b1, 1'b0, 1'b1, 2'b00}, // c11 R6
        {4'd5, 1'b0, 5'b00000, 1'b0, 1'b1, 1'b0, 2'b00}, // c12 R5 zero off-sample ignored
        {4'd5, 1'b0, 5'b00010, 1'b0, 1'b1, 1'b0, 2'b00}, // c13 R5
        {4'd4, 1'b0, 5'b00000, 1'b1, 1'b0, 1'b1, 2'b00}, // c14 R4
        {4'd9, 1'b1, 5'b00000, 1'b1, 1'b0, 1'b1, 2'b00}, // c15 R9 budget end + reload
        {4'd8, 1'b1, 5'b00000, 1'b0, 1'b1, 1'b0, 2'b01}, // c16 R8 strobe, R3 nf ignored
        {4'd5, 1'b0, 5'b00000, 1'b0, 1'b1, 1'b0, 2'b00}, // c17 R5 slot 0 converges
        {4'd3, 1'b0, 5'b00000, 1'b1, 1'b0, 1'b0, 2'b01}, // c18 R3 slot 1 idle, R7
        {4'd6, 1'b0, 5'b00000, 1'b1, 1'b0, 1'b0, 2'b00}, // c19 R6
        {4'd6, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 2'b00}  // c20 R6
    };

    task automatic check_out(input string tag, input logic [4:0] got, input logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {slot,ce,ve,hd} got %b expected %b", tag, got, exp);
        end
    endtask

    initial begin : watchdog
        #100000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R1 in reset", {chk_slot, chk_en, var_en, hd_strobe}, 5'b00000);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            new_frame = VEC[k][10];
            parity    = VEC[k][9:5];
            check_out($sformatf("R%0d vector c%0d", VEC[k][14:11], k),
                      {chk_slot, chk_en, var_en, hd_strobe}, VEC[k][4:0]);
            @(negedge clk);
        end
        new_frame = 1'b0;
        parity    = '0;

        // R1: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        check_out("R1 mid-run reset", {chk_slot, chk_en, var_en, hd_strobe}, 5'b00000);
        @(negedge clk);
        rst = 1'b0;

        // R8: frame in slot 1 never converges, budget of 3 iterations
        for (int c = 0; c < 16; c++) begin
            new_frame = (c == 1);
            parity    = 5'b01000;
            if (c == 14)
                check_out("R8 budget strobe", {chk_slot, chk_en, var_en, hd_strobe}, 5'b10010);
            else
                check_out($sformatf("R8 no early strobe c%0d", c), {3'b000, hd_strobe}, 5'b00000);
            @(negedge clk);
        end
        // R6: slot 1 stays off after its budget
        check_out("R6 after budget", {chk_slot, chk_en, var_en, hd_strobe}, 5'b00000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule